// File: doc/BRIEF.md
# Parallel I/O Port with Edge Capture

This block is a general-purpose parallel port of up to 32 lines behind a small word-addressed register interface. Each line can be an input or an output. An output line is driven through a separate value and enable pair so a pad ring outside the block can build the tri-state buffer. Input lines are brought into the clock domain by a synchroniser before any logic looks at them.

The interrupt source is picked when the block is built, by a parameter; software cannot change it. In the three edge variants, every line keeps a sticky capture bit that software clears by writing ones. A handler can therefore loop, clearing what it has serviced, until no captured line remains enabled. In the level variant, the interrupt simply follows the enabled lines that are high.

The register port is a plain strobe interface, not a valid/ready stream. A write completes in the cycle `bus_wr_en` is high. Read data is registered, so it appears in the cycle after `bus_rd_en` and is zero in any cycle after a cycle without a read. The port never stalls, so there is no back-pressure.

Top module: `pio_capture_ctrl`

## Requirements
- R1: When `bus_rd_en` is high, `bus_rd_data` in the next cycle holds the register chosen by `bus_addr[3:2]`. Select 0 is the line-level view: the output value for lines whose direction bit is 1, and the synchronised input for the others. Select 1 is direction, select 2 is the interrupt enable, and select 3 is the capture register. After a cycle with `bus_rd_en` low, `bus_rd_data` is zero.
- R2: A write with select 0 loads the output value register, and `pin_out` shows the new value from the next cycle.
- R3: A write with select 1 loads the direction register, and `pin_oe` shows it from the next cycle. A bit of 1 makes that line an output.
- R4: Each input passes through a two-flop synchroniser. An edge is found by comparing the synchronised level with its value one cycle earlier. A capture bit becomes readable three clock edges after the input changes, and it is never set without a matching edge.
- R5: A write with select 3 clears every capture bit whose write-data bit is 1 and leaves the others unchanged.
- R6: In the edge variants, `irq` is high exactly when some line has both its capture bit and its enable bit (select 2, 1 means enabled) set.
- R7: In the level variant, `irq` is high exactly when some enabled line reads 1 in the line-level view, and the capture register stays zero.
- R8: Reset, which is asynchronous and active low, clears the output value, direction, enable, capture and read-data registers. As a result every line starts as an input with interrupts disabled.
- R9: Register bits at or above `LINES` read as zero, and write data in those bits has no effect.
- R10: If an edge and a clearing write hit the same capture bit in the same cycle, the bit ends set.
- R11: The `TRIG` parameter selects the interrupt source: 0 is rising edge, 1 is falling edge, 2 is either edge, and 3 is level high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Byte address; bits [3:2] select the register |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_data | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rd_data | output | 32 | Registered read data |
| pin_in | input | LINES | Raw line levels from the pads |
| pin_out | output | LINES | Output values toward the pads |
| pin_oe | output | LINES | Output enables toward the pads |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker tests the following on every cycle:
- `pin_out` and `pin_oe` follow their writes one cycle later.
- A clearing write removes only bits that no edge sets again in the same cycle.
- An edge always wins over a clear.
- Capture bits never appear without an edge.
- Idle reads return zero, and upper read bits are zero.
- In the level variant, the capture register stays empty.

Some behaviour only the bench scenarios can show. These are the three-edge latency through the synchroniser, the choice of edge for each `TRIG` value, and how `irq` combines capture or levels with the enables. The bench shows them by running all four variants side by side against a reference model. It checks them over every placement of a clear relative to an edge, and over long random traffic.

// File: rtl/pio_pkg.sv
package pio_pkg;

  localparam int unsigned REG_W = 32;

  typedef enum logic [1:0] {
    TRIG_RISE  = 2'd0,
    TRIG_FALL  = 2'd1,
    TRIG_BOTH  = 2'd2,
    TRIG_LEVEL = 2'd3
  } trig_e;

  typedef enum logic [1:0] {
    SEL_LEVELS = 2'd0,
    SEL_DIR    = 2'd1,
    SEL_ENABLE = 2'd2,
    SEL_CAPT   = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(STAGES); s++) chain[s] <= '0;
    end else begin
      chain[0] <= async_in;
      for (int s = 1; s < int'(STAGES); s++) chain[s] <= chain[s-1];
    end
  end

  assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/pio_edge_detect.sv
module pio_edge_detect
  import pio_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter trig_e       TRIG  = TRIG_RISE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] ev
);

  generate
    if (TRIG == TRIG_LEVEL) begin : g_level
      logic unused_level;
      assign unused_level = ^{level, clk, rst_n};
      assign ev = '0;
    end else begin : g_edge
      logic [WIDTH-1:0] prev_q;
      logic [WIDTH-1:0] rise, fall;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level;
      end

      assign rise = level & ~prev_q;
      assign fall = ~level & prev_q;

      if (TRIG == TRIG_RISE) begin : g_rise
        assign ev = rise;
      end else if (TRIG == TRIG_FALL) begin : g_fall
        assign ev = fall;
      end else begin : g_both
        assign ev = rise | fall;
      end
    end
  endgenerate

endmodule

// File: rtl/pio_capture.sv
module pio_capture #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] ev,
  input  logic [WIDTH-1:0] clr,
  output logic [WIDTH-1:0] capt
);

  // an edge arriving in the clearing cycle survives the clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) capt <= '0;
    else        capt <= (capt & ~clr) | ev;
  end

endmodule

// File: rtl/pio_capture_ctrl.sv
module pio_capture_ctrl
  import pio_pkg::*;
#(
  parameter int unsigned LINES = 32,
  parameter trig_e       TRIG  = TRIG_RISE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       bus_addr,
  input  logic             bus_wr_en,
  input  logic [31:0]      bus_wr_data,
  input  logic             bus_rd_en,
  output logic [31:0]      bus_rd_data,
  input  logic [LINES-1:0] pin_in,
  output logic [LINES-1:0] pin_out,
  output logic [LINES-1:0] pin_oe,
  output logic             irq
);

  reg_sel_e         sel;
  logic [LINES-1:0] wd;
  logic [LINES-1:0] sync_lvl;
  logic [LINES-1:0] edge_ev;
  logic [LINES-1:0] capt_q;
  logic [LINES-1:0] capt_clr;
  logic [LINES-1:0] out_q, dir_q, ena_q;
  logic [LINES-1:0] line_view;
  logic [LINES-1:0] rd_mux;
  logic [REG_W-1:0] rd_q;
  logic             unused_bits;

  assign sel         = reg_sel_e'(bus_addr[3:2]);
  assign wd          = bus_wr_data[LINES-1:0];
  assign unused_bits = ^{bus_addr[1:0], bus_wr_data};

  pio_sync #(.WIDTH(LINES), .STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (sync_lvl)
  );

  pio_edge_detect #(.WIDTH(LINES), .TRIG(TRIG)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (sync_lvl),
    .ev    (edge_ev)
  );

  assign capt_clr = (bus_wr_en && sel == SEL_CAPT) ? wd : '0;

  pio_capture #(.WIDTH(LINES)) u_capt (
    .clk   (clk),
    .rst_n (rst_n),
    .ev    (edge_ev),
    .clr   (capt_clr),
    .capt  (capt_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
      ena_q <= '0;
    end else if (bus_wr_en) begin
      case (sel)
        SEL_LEVELS: out_q <= wd;
        SEL_DIR:    dir_q <= wd;
        SEL_ENABLE: ena_q <= wd;
        default:    ;
      endcase
    end
  end

  assign line_view = (dir_q & out_q) | (~dir_q & sync_lvl);

  always_comb begin
    case (sel)
      SEL_LEVELS: rd_mux = line_view;
      SEL_DIR:    rd_mux = dir_q;
      SEL_ENABLE: rd_mux = ena_q;
      default:    rd_mux = capt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rd_q <= '0;
    else if (bus_rd_en) rd_q <= REG_W'(rd_mux);
    else                rd_q <= '0;
  end

  generate
    if (TRIG == TRIG_LEVEL) begin : g_irq_level
      assign irq = |(line_view & ena_q);
    end else begin : g_irq_edge
      assign irq = |(capt_q & ena_q);
    end
  endgenerate

  assign bus_rd_data = rd_q;
  assign pin_out     = out_q;
  assign pin_oe      = dir_q;

endmodule

// File: rtl/pio_capture_ctrl_checks.sv
module pio_capture_ctrl_checks
  import pio_pkg::*;
#(
  parameter int unsigned LINES = 32,
  parameter trig_e       TRIG  = TRIG_RISE
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       bus_addr,
  input logic             bus_wr_en,
  input logic [31:0]      bus_wr_data,
  input logic             bus_rd_en,
  input logic [31:0]      bus_rd_data,
  input logic [LINES-1:0] pin_out,
  input logic [LINES-1:0] pin_oe,
  input logic [LINES-1:0] capt,
  input logic [LINES-1:0] ev
);

  logic [LINES-1:0] wdl;
  logic [63:0]      rd_wide;
  assign wdl     = bus_wr_data[LINES-1:0];
  assign rd_wide = {32'd0, bus_rd_data};

  a_r2_out_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr[3:2] == 2'd0) |=> (pin_out == $past(wdl)));

  a_r3_oe_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr[3:2] == 2'd1) |=> (pin_oe == $past(wdl)));

  a_r5_clear_removes_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr[3:2] == 2'd3) |=> ((capt & $past(wdl) & ~$past(ev)) == '0));

  a_r10_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((capt & $past(ev)) == $past(ev)));

  a_r4_set_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ((capt & ~$past(capt) & ~$past(ev)) == '0));

  a_r1_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_en |=> (bus_rd_data == 32'd0));

  a_r9_upper_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_wide >> LINES) == 64'd0));

  generate
    if (TRIG == TRIG_LEVEL) begin : g_lvl
      a_r7_level_capture_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (capt == '0));
    end
  endgenerate

endmodule

bind pio_capture_ctrl pio_capture_ctrl_checks #(.LINES(LINES), .TRIG(TRIG)) u_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_wr_en   (bus_wr_en),
  .bus_wr_data (bus_wr_data),
  .bus_rd_en   (bus_rd_en),
  .bus_rd_data (bus_rd_data),
  .pin_out     (pin_out),
  .pin_oe      (pin_oe),
  .capt        (capt_q),
  .ev          (edge_ev)
);

// File: tb/test_pio_capture_ctrl.sv
`timescale 1ns/1ps
module test_pio_capture_ctrl;
  import pio_pkg::*;

  localparam int unsigned N = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   addr = '0;
  logic         wr_en = 1'b0;
  logic [31:0]  wr_data = '0;
  logic         rd_en = 1'b0;
  logic [N-1:0] pins = '0;

  logic [31:0]  d_rd  [4];
  logic [N-1:0] d_out [4];
  logic [N-1:0] d_oe  [4];
  logic         d_irq [4];

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  string phase = "R8 reset";

  always #5 clk = ~clk;

  pio_capture_ctrl #(.LINES(N), .TRIG(TRIG_RISE)) i_pio_capture_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr_en(wr_en), .bus_wr_data(wr_data),
    .bus_rd_en(rd_en), .bus_rd_data(d_rd[0]), .pin_in(pins), .pin_out(d_out[0]),
    .pin_oe(d_oe[0]), .irq(d_irq[0]));
  pio_capture_ctrl #(.LINES(N), .TRIG(TRIG_FALL)) i_pio_capture_ctrl_fall (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr_en(wr_en), .bus_wr_data(wr_data),
    .bus_rd_en(rd_en), .bus_rd_data(d_rd[1]), .pin_in(pins), .pin_out(d_out[1]),
    .pin_oe(d_oe[1]), .irq(d_irq[1]));
  pio_capture_ctrl #(.LINES(N), .TRIG(TRIG_BOTH)) i_pio_capture_ctrl_both (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr_en(wr_en), .bus_wr_data(wr_data),
    .bus_rd_en(rd_en), .bus_rd_data(d_rd[2]), .pin_in(pins), .pin_out(d_out[2]),
    .pin_oe(d_oe[2]), .irq(d_irq[2]));
  pio_capture_ctrl #(.LINES(N), .TRIG(TRIG_LEVEL)) i_pio_capture_ctrl_level (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr_en(wr_en), .bus_wr_data(wr_data),
    .bus_rd_en(rd_en), .bus_rd_data(d_rd[3]), .pin_in(pins), .pin_out(d_out[3]),
    .pin_oe(d_oe[3]), .irq(d_irq[3]));

  // reference model: index m is the TRIG value (R11)
  logic [N-1:0] m_s1, m_s2, m_prev, m_lat, m_dir, m_ena;
  logic [N-1:0] m_cap [4];
  logic [31:0]  m_rd  [4];

  function automatic logic [N-1:0] view();
    return (m_dir & m_lat) | (~m_dir & m_s2);
  endfunction

  function automatic logic [N-1:0] edges(int m);
    logic [N-1:0] up, dn;
    up = m_s2 & ~m_prev;
    dn = ~m_s2 & m_prev;
    case (m)
      0: return up;
      1: return dn;
      2: return up | dn;
      default: return '0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0;
      m_lat <= '0; m_dir <= '0; m_ena <= '0;
      for (int m = 0; m < 4; m++) begin m_cap[m] <= '0; m_rd[m] <= '0; end
    end else begin
      logic [N-1:0] clr;
      logic [N-1:0] val;
      clr = (wr_en && addr[3:2] == 2'd3) ? wr_data[N-1:0] : '0;
      for (int m = 0; m < 4; m++) begin
        case (addr[3:2])
          2'd0: val = view();
          2'd1: val = m_dir;
          2'd2: val = m_ena;
          default: val = m_cap[m];
        endcase
        m_rd[m]  <= rd_en ? {{(32-N){1'b0}}, val} : 32'd0;
        m_cap[m] <= (m_cap[m] & ~clr) | edges(m);
      end
      if (wr_en && addr[3:2] == 2'd0) m_lat <= wr_data[N-1:0];
      if (wr_en && addr[3:2] == 2'd1) m_dir <= wr_data[N-1:0];
      if (wr_en && addr[3:2] == 2'd2) m_ena <= wr_data[N-1:0];
      m_s1 <= pins; m_s2 <= m_s1; m_prev <= m_s2;
    end
  end

  task automatic check_all();
    for (int m = 0; m < 4; m++) begin
      logic exp_irq;
      exp_irq = (m == 3) ? |(view() & m_ena) : |(m_cap[m] & m_ena);
      n_vec++;
      if (d_rd[m] !== m_rd[m]) begin
        n_bad++;
        $display("FAIL R1 [%s] mode %0d rd_data actual %h expected %h", phase, m, d_rd[m], m_rd[m]);
      end
      n_vec++;
      if (d_out[m] !== m_lat) begin
        n_bad++;
        $display("FAIL R2 [%s] mode %0d pin_out actual %h expected %h", phase, m, d_out[m], m_lat);
      end
      n_vec++;
      if (d_oe[m] !== m_dir) begin
        n_bad++;
        $display("FAIL R3 [%s] mode %0d pin_oe actual %h expected %h", phase, m, d_oe[m], m_dir);
      end
      n_vec++;
      if (d_irq[m] !== exp_irq) begin
        n_bad++;
        $display("FAIL %s [%s] mode %0d irq actual %b expected %b",
                 (m == 3) ? "R7" : "R6", phase, m, d_irq[m], exp_irq);
      end
    end
  endtask

  // one cycle: compare at the falling edge, then drive the next inputs
  task automatic step(logic [N-1:0] p, logic we, logic [1:0] sel, logic [31:0] wd, logic re);
    @(negedge clk);
    check_all();
    pins = p; wr_en = we; addr = {sel, 2'b00}; wr_data = wd; rd_en = re;
  endtask

  task automatic read_all(logic [N-1:0] p);
    for (int s = 0; s < 4; s++) step(p, 1'b0, 2'(s), 32'd0, 1'b1);
  endtask

  initial begin
    // R8: reset state observed with reads requested
    for (int i = 0; i < 3; i++) step('0, 1'b0, 2'(i), 32'd0, 1'b1);
    @(negedge clk); check_all(); rst_n = 1'b1;
    read_all('0);

    phase = "R2 R3 R9 writes";
    step('0, 1'b1, 2'd0, 32'hFFFF_FA5A, 1'b0);
    step('0, 1'b1, 2'd1, 32'hFFFF_F0F0, 1'b0);
    step('0, 1'b1, 2'd2, 32'hFFFF_FFFF, 1'b0);
    read_all('0);

    phase = "R4 R11 edges";
    step(12'h00F, 1'b0, 2'd3, 32'd0, 1'b1);
    for (int i = 0; i < 4; i++) step(12'h00F, 1'b0, 2'd3, 32'd0, 1'b1);
    step(12'h0F0, 1'b0, 2'd3, 32'd0, 1'b1);
    for (int i = 0; i < 4; i++) step(12'h0F0, 1'b0, 2'd3, 32'd0, 1'b1);
    read_all(12'h0F0);

    phase = "R5 clear";
    step(12'h0F0, 1'b1, 2'd3, 32'h0000_000F, 1'b0);
    read_all(12'h0F0);
    step(12'h0F0, 1'b1, 2'd3, 32'hFFFF_FFFF, 1'b0);
    read_all(12'h0F0);

    phase = "R10 edge against clear";
    for (int d = 0; d < 5; d++) begin
      logic [N-1:0] p;
      p = 12'h0F0 ^ 12'(1 << d);
      step(p, 1'b0, 2'd3, 32'd0, 1'b1);
      for (int w = 0; w < d; w++) step(p, 1'b0, 2'd3, 32'd0, 1'b1);
      step(p, 1'b1, 2'd3, 32'hFFFF_FFFF, 1'b0);
      for (int w = 0; w < 3; w++) step(p, 1'b0, 2'd3, 32'd0, 1'b1);
      step(12'h0F0, 1'b0, 2'd3, 32'd0, 1'b0);
      for (int w = 0; w < 4; w++) step(12'h0F0, 1'b1, 2'd3, 32'hFFFF_FFFF, 1'b1);
    end

    phase = "R7 level";
    step(12'h000, 1'b1, 2'd1, 32'h0000_0000, 1'b0);
    step(12'h000, 1'b1, 2'd2, 32'h0000_0001, 1'b0);
    for (int i = 0; i < 4; i++) step(12'h001, 1'b0, 2'd0, 32'd0, 1'b1);
    step(12'h001, 1'b1, 2'd2, 32'h0000_0002, 1'b0);
    step(12'h001, 1'b1, 2'd0, 32'h0000_0002, 1'b0);
    step(12'h001, 1'b1, 2'd1, 32'h0000_0002, 1'b0);
    for (int i = 0; i < 4; i++) step(12'h000, 1'b0, 2'd0, 32'd0, 1'b1);

    phase = "R1 random";
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(12'($urandom), r[0] & r[1], r[3:2], $urandom, r[4]);
    end

    @(negedge clk); check_all();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(150000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog [%s] actual timeout expected completion", phase);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule